// File: doc/BRIEF.md
# Indirect CSR Access Synchronizer

This block lets a host register port reach up to 256 control/status registers that live in a separate MAC clock domain. The host never touches those registers directly. It loads a 32-bit data register, then writes a command register that holds an 8-bit target address, a direction bit and a busy bit. Setting the busy bit launches one access. The request crosses into the MAC domain as a toggle through a two-flop synchronizer. There it becomes a single-cycle register strobe. Completion travels back the same way, and the busy bit then clears by itself.

For a read, the value returned by the MAC register is loaded into the data register before busy clears. The host can therefore poll the command register until bit 31 is 0 and then read the data register. Address, direction and write data are copied into holding registers when the access starts, so they stay steady while the MAC domain samples them. Writes from the host while an access is in flight are dropped.

Top module: `csr_xdom_bridge`

## Requirements
- R1: After reset, reads of the command register (offset 0xA4) and the data register (offset 0xA8) both return 0.
- R2: A command register read returns busy in bit 31, direction in bit 30 (1 = read of a MAC register, 0 = write) and the address in bits 7:0. Bits 29:8 read as 0. Host read data appears on `h_rdata` in the clock cycle after `h_rd`.
- R3: Writing the command register with bit 31 clear updates only the address and direction fields and starts no MAC access.
- R4: A write access (bit 30 = 0) produces exactly one MAC strobe, with `m_we` = 1, `m_addr` equal to the command address and `m_wdata` equal to the data register value held when the access started.
- R5: A read access (bit 30 = 1) produces exactly one MAC strobe with `m_we` = 0. The `m_rdata` value of that strobe cycle is in the data register by the time busy reads 0.
- R6: Writing the command register with bit 31 set makes busy read 1 from the next host cycle on. Busy stays 1 until the MAC acknowledge has been synchronized back into the host domain, then returns to 0 with no further host action.
- R7: While busy is 1, host writes to the command and data registers have no effect on the access in flight or on the register contents.
- R8: `m_stb` is never high for two MAC cycles in a row.
- R9: Host reads of any offset other than 0xA4 and 0xA8 return 0, and host writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host clock |
| h_rst | input | 1 | Host synchronous reset, active high |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Registered host read data |
| m_clk | input | 1 | MAC clock |
| m_rst | input | 1 | MAC synchronous reset, active high |
| m_stb | output | 1 | One-cycle MAC register access strobe |
| m_we | output | 1 | 1 for a MAC register write, valid with `m_stb` |
| m_addr | output | 8 | MAC register address, valid with `m_stb` |
| m_wdata | output | 32 | MAC register write data, valid with `m_stb` |
| m_rdata | input | 32 | MAC register read data for `m_addr`, same cycle |

## Verification
The in-RTL properties check on every cycle that busy rises only from a command write with bit 31 set, and falls only on a synchronized acknowledge. They also check that the command fields and the data register stay frozen during an access, that the MAC strobe lasts one cycle, and that an acknowledge toggle always follows a strobe. The bench scenarios cover everything that involves values end to end. That includes write data landing at the right MAC address, read data reaching the data register, exactly one strobe per access, and writes during busy or to unmapped offsets leaving the visible registers unchanged.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  localparam int DW       = 32;
  localparam int RAW      = 8;
  localparam int HAW      = 8;
  localparam int BUSY_BIT = 31;
  localparam int DIR_BIT  = 30;
  localparam logic [HAW-1:0] OFS_CMD  = 8'hA4;
  localparam logic [HAW-1:0] OFS_DATA = 8'hA8;
endpackage

// File: rtl/csrx_bit_sync.sv
module csrx_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/csrx_host_side.sv
module csrx_host_side
  import csrx_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic           rd,
  input  logic [HAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic           ack_s,
  input  logic [DW-1:0]  mac_rd,
  output logic           req_tog,
  output logic [RAW-1:0] hold_addr,
  output logic           hold_we,
  output logic [DW-1:0]  hold_wdata
);
  localparam int RSV_W = DIR_BIT - RAW;

  logic           busy_q, dir_q, ack_seen_q;
  logic [RAW-1:0] caddr_q;
  logic [DW-1:0]  data_q;
  logic           ack_evt, wr_cmd, wr_data;
  logic [DW-1:0]  cmd_view;

  assign ack_evt  = ack_s != ack_seen_q;
  assign wr_cmd   = wr && (addr == OFS_CMD);
  assign wr_data  = wr && (addr == OFS_DATA);
  assign cmd_view = {busy_q, dir_q, {RSV_W{1'b0}}, caddr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      dir_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      caddr_q    <= '0;
      data_q     <= '0;
      req_tog    <= 1'b0;
      hold_addr  <= '0;
      hold_we    <= 1'b0;
      hold_wdata <= '0;
    end else if (ack_evt) begin
      ack_seen_q <= ack_s;
      if (busy_q) begin
        busy_q <= 1'b0;
        if (dir_q) data_q <= mac_rd;
      end
    end else if (!busy_q) begin
      if (wr_cmd) begin
        caddr_q <= wdata[RAW-1:0];
        dir_q   <= wdata[DIR_BIT];
        if (wdata[BUSY_BIT]) begin
          busy_q     <= 1'b1;
          req_tog    <= ~req_tog;
          hold_addr  <= wdata[RAW-1:0];
          hold_we    <= ~wdata[DIR_BIT];
          hold_wdata <= data_q;
        end
      end
      if (wr_data) data_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) begin
      case (addr)
        OFS_CMD:  rdata <= cmd_view;
        OFS_DATA: rdata <= data_q;
        default:  rdata <= '0;
      endcase
    end
  end

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(wr_cmd && wdata[BUSY_BIT]));
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(ack_evt));
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(data_q));
  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(caddr_q) && $stable(dir_q) && $stable(hold_wdata)));
endmodule

// File: rtl/csrx_mac_side.sv
module csrx_mac_side
  import csrx_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           req_s,
  input  logic [RAW-1:0] hold_addr,
  input  logic           hold_we,
  input  logic [DW-1:0]  hold_wdata,
  output logic           stb,
  output logic           we,
  output logic [RAW-1:0] addr,
  output logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  rdata,
  output logic           ack_tog,
  output logic [DW-1:0]  rd_hold
);
  logic req_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen_q <= 1'b0;
      stb        <= 1'b0;
      we         <= 1'b0;
      addr       <= '0;
      wdata      <= '0;
      ack_tog    <= 1'b0;
      rd_hold    <= '0;
    end else begin
      stb <= 1'b0;
      if (req_s != req_seen_q) begin
        req_seen_q <= req_s;
        stb        <= 1'b1;
        we         <= hold_we;
        addr       <= hold_addr;
        wdata      <= hold_wdata;
      end
      if (stb) begin
        ack_tog <= ~ack_tog;
        if (!we) rd_hold <= rdata;
      end
    end
  end

  // R8
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
  // R4
  ack_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_tog != $past(ack_tog)) |-> $past(stb));
endmodule

// File: rtl/csr_xdom_bridge.sv
module csr_xdom_bridge
  import csrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           h_clk,
  input  logic           h_rst,
  input  logic           h_wr,
  input  logic           h_rd,
  input  logic [HAW-1:0] h_addr,
  input  logic [DW-1:0]  h_wdata,
  output logic [DW-1:0]  h_rdata,
  input  logic           m_clk,
  input  logic           m_rst,
  output logic           m_stb,
  output logic           m_we,
  output logic [RAW-1:0] m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic [DW-1:0]  m_rdata
);
  logic           req_tog, req_s, ack_tog, ack_s;
  logic [RAW-1:0] hold_addr;
  logic           hold_we;
  logic [DW-1:0]  hold_wdata, rd_hold;

  csrx_host_side u_host (
    .clk(h_clk), .rst(h_rst), .wr(h_wr), .rd(h_rd), .addr(h_addr),
    .wdata(h_wdata), .rdata(h_rdata), .ack_s(ack_s), .mac_rd(rd_hold),
    .req_tog(req_tog), .hold_addr(hold_addr), .hold_we(hold_we),
    .hold_wdata(hold_wdata)
  );

  csrx_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(m_clk), .rst(m_rst), .d(req_tog), .q(req_s)
  );

  csrx_mac_side u_mac (
    .clk(m_clk), .rst(m_rst), .req_s(req_s), .hold_addr(hold_addr),
    .hold_we(hold_we), .hold_wdata(hold_wdata), .stb(m_stb), .we(m_we),
    .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata), .ack_tog(ack_tog),
    .rd_hold(rd_hold)
  );

  csrx_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(h_clk), .rst(h_rst), .d(ack_tog), .q(ack_s)
  );
endmodule

// File: tb/sim_csr_xdom_bridge.sv
module sim_csr_xdom_bridge;
  localparam logic [7:0] CMD  = 8'hA4;
  localparam logic [7:0] DATA = 8'hA8;

  logic        h_clk = 0, m_clk = 0, h_rst = 1, m_rst = 1;
  logic        h_wr = 0, h_rd = 0;
  logic [7:0]  h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic        m_stb, m_we;
  logic [7:0]  m_addr;
  logic [31:0] m_wdata, m_rdata;

  logic [31:0] mac_mem [256];
  logic [31:0] ref_mem [256];
  int stb_cnt = 0;
  int total = 0, bad = 0;

  always #2.5 h_clk = ~h_clk;
  always #3.5 m_clk = ~m_clk;

  csr_xdom_bridge u0 (
    .h_clk(h_clk), .h_rst(h_rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .m_clk(m_clk), .m_rst(m_rst),
    .m_stb(m_stb), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata)
  );

  assign m_rdata = mac_mem[m_addr];

  always @(posedge m_clk) begin
    if (m_stb) begin
      stb_cnt <= stb_cnt + 1;
      if (m_we) mac_mem[m_addr] <= m_wdata;
    end
  end

  function automatic logic [31:0] seed_val(int i);
    return (i * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] cmd_word(bit busy, bit rd, logic [7:0] a);
    return {busy, rd, 22'b0, a};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hw(logic [7:0] a, logic [31:0] d);
    @(negedge h_clk);
    h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge h_clk);
    h_wr = 0;
  endtask

  task automatic hr(logic [7:0] a, output logic [31:0] d);
    @(negedge h_clk);
    h_rd = 1; h_addr = a;
    @(negedge h_clk);
    h_rd = 0;
    d = h_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    bit done = 0;
    for (int i = 0; i < 200; i++) begin
      hr(CMD, v);
      if (!v[31]) begin done = 1; break; end
    end
    check(done, "R6 busy self-clear", v, {1'b0, v[30:0]});
  endtask

  task automatic access(logic [7:0] a, bit rd, logic [31:0] d);
    logic [31:0] v;
    int c0;
    c0 = stb_cnt;
    if (!rd) hw(DATA, d);
    hw(CMD, cmd_word(1, rd, a));
    hr(CMD, v);
    check(v[31] == 1'b1, "R6 busy set", v, cmd_word(1, rd, a));
    wait_idle();
    check(stb_cnt == c0 + 1, "R8 one strobe per access", stb_cnt, c0 + 1);
    if (rd) begin
      hr(DATA, v);
      check(v == ref_mem[a], "R5 read data", v, ref_mem[a]);
    end else begin
      ref_mem[a] = d;
      check(mac_mem[a] == d, "R4 write data", mac_mem[a], d);
    end
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0;
    for (int i = 0; i < 256; i++) begin
      mac_mem[i] = seed_val(i);
      ref_mem[i] = seed_val(i);
    end
    void'($urandom(32'd1234));
    repeat (10) @(negedge h_clk);
    h_rst = 0; m_rst = 0;
    repeat (4) @(negedge h_clk);

    // R1 reset state
    hr(CMD, v);  check(v == 0, "R1 cmd reset", v, 0);
    hr(DATA, v); check(v == 0, "R1 data reset", v, 0);

    // R2 / R3: busy clear writes fields only, reserved bits read zero
    c0 = stb_cnt;
    hw(CMD, 32'h7FFF_FFFF);
    repeat (30) @(negedge h_clk);
    hr(CMD, v);
    check(v == cmd_word(0, 1, 8'hFF), "R2 cmd fields", v, cmd_word(0, 1, 8'hFF));
    check(stb_cnt == c0, "R3 no access", stb_cnt, c0);

    // R9 unmapped offsets
    hw(DATA, 32'h1234_5678);
    hw(8'h10, 32'hDEAD_BEEF);
    hr(8'h10, v); check(v == 0, "R9 unmapped read", v, 0);
    hr(DATA, v);  check(v == 32'h1234_5678, "R9 unmapped write", v, 32'h1234_5678);

    // R4 / R5 directed corners
    access(8'h00, 0, 32'hFFFF_FFFF);
    access(8'hFF, 0, 32'h0000_0001);
    access(8'h00, 1, 0);
    access(8'hFF, 1, 0);

    // R7 writes during a read access ignored
    c0 = stb_cnt;
    hw(CMD, cmd_word(1, 1, 8'h42));
    hw(DATA, 32'hBAD0_BAD0);
    hw(CMD, cmd_word(1, 0, 8'h17));
    wait_idle();
    hr(DATA, v); check(v == ref_mem[8'h42], "R7 data kept", v, ref_mem[8'h42]);
    hr(CMD, v);  check(v == cmd_word(0, 1, 8'h42), "R7 cmd kept", v, cmd_word(0, 1, 8'h42));
    check(stb_cnt == c0 + 1, "R7 single access", stb_cnt, c0 + 1);

    // R7 writes during a write access ignored
    hw(DATA, 32'hC0DE_0001);
    hw(CMD, cmd_word(1, 0, 8'h33));
    hw(DATA, 32'h0BAD_0BAD);
    wait_idle();
    ref_mem[8'h33] = 32'hC0DE_0001;
    check(mac_mem[8'h33] == 32'hC0DE_0001, "R7 write data kept", mac_mem[8'h33], 32'hC0DE_0001);

    // random mix for R4 / R5
    for (int k = 0; k < 40; k++) begin
      logic [7:0]  a;
      bit          rd;
      logic [31:0] d;
      a  = 8'($urandom % 256);
      rd = 1'($urandom % 2);
      d  = $urandom;
      access(a, rd, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule